// File: doc/BRIEF.md
# Over-Temperature Alarm Peripheral

This block watches a stream of signed temperature samples, given in millidegrees Celsius, and sorts each sample into one of four over-temperature stages, 0 (normal) up to 3 (most severe). Three trip points divide the stages. Their values come from one of four threshold sets, and software picks the set with a 2-bit index. Two parameters choose the hardware generation and its major revision. Between them they fix the trip-point table and the way the stage appears in the status register.

Software talks to the block over a simple byte-wide register port. Writes are synchronous and reads are combinational. Through this port software reads the identification bytes and the status, sets the threshold index, sets the stage-2 shutdown override and the monitoring-rate bit, and turns the alarm on. The block pulses an interrupt each time the stage changes. It also drives a shutdown request when the temperature reaches the critical stages.

Top module: `therm_alarm`

## Requirements
- R1: Identification reads are constant. Address 0x01 returns the REV parameter, 0x04 returns 0x09, and 0x05 returns 0x08 when GEN=1 or 0x09 when GEN=2. An address that maps to no register reads 0x00.
- R2: The shutdown-control register sits at address 0x40 and keeps only bits 6 (override), 3 (rate) and 1:0 (threshold index). The alarm-control register sits at 0x46 and keeps only bit 7 (force-on). Both registers reset to 0x00 and read back their kept bits, with all other bits at 0.
- R3: Trip point k for index i is B_k + 5000*i millidegrees. With GEN=2 and REV≥1 the bases are B = 90000, 110000, 140000. Otherwise they are 105000, 125000, 145000. On a clock edge where temp_vld is high and force-on is set, the stage becomes the number of trip points that the sample is at or above. Without a valid sample the stage holds.
- R4: While force-on is clear, the stage goes to 0 at the next edge and samples have no effect.
- R5: alarm_irq is high for exactly one cycle, in the cycle right after an edge that changed the stage, and is low at all other times.
- R6: shutdown is high when the stage is 3, or when the stage is 2 and the override bit is clear. Otherwise it is low.
- R7: The status register is at 0x08. For GEN=1 it reads the stage in bits 1:0. For GEN=2 it reads a 3-bit state in bits 6:4: 0 for stage 0, and 2*stage-1 for stages 1 to 3. All other bits read 0.
- R8: Writes to the identification or status addresses have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| temp_mc | input | TW | Signed temperature sample, millidegrees C |
| temp_vld | input | 1 | Sample valid |
| alarm_irq | output | 1 | One-cycle pulse on stage change |
| shutdown | output | 1 | Shutdown request |

## Verification
On every cycle the assertions check four things: the interrupt pulses exactly when the stage register moves, the stage drops to zero once force-on clears, the stage holds between samples, and the shutdown and identification outputs stay consistent with the stage and the address. The bench's scenarios are what show that the trip points are correct for each threshold index and both tables. They also show the boundary samples exactly at a trip point, how the control bits are masked, that writes to read-only addresses are ignored, and the status encoding under both generations.

// File: rtl/therm_alarm.sv
module therm_alarm #(
  parameter int       GEN  = 2,
  parameter bit [7:0] REV  = 8'h01,
  parameter int       TW   = 32,
  parameter int       STEP = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic signed [TW-1:0] temp_mc,
  input  logic                 temp_vld,
  output logic                 alarm_irq,
  output logic                 shutdown
);
  localparam bit NEWTAB = (GEN == 2) && (REV != 8'h00);
  localparam int B0 = NEWTAB ? 90000  : 105000;
  localparam int B1 = NEWTAB ? 110000 : 125000;
  localparam int B2 = NEWTAB ? 140000 : 145000;
  localparam logic [7:0] A_REV = 8'h01, A_TYPE = 8'h04, A_SUB = 8'h05,
                         A_STAT = 8'h08, A_SDC = 8'h40, A_ALC = 8'h46;
  localparam logic [7:0] SDC_MASK = 8'h4B, ALC_MASK = 8'h80;
  localparam logic [7:0] SUBTYPE = (GEN == 1) ? 8'h08 : 8'h09;

  logic [7:0] sdc, alc;
  logic [1:0] stage, stage_calc, stage_nx;
  logic [2:0] hit;
  logic [2:0] gstate;
  logic       irq_q;

  for (genvar k = 0; k < 3; k++) begin : g_trip
    localparam int BK = (k == 0) ? B0 : (k == 1) ? B1 : B2;
    logic signed [TW-1:0] trip;
    assign trip   = TW'(BK + STEP * int'(sdc[1:0]));
    assign hit[k] = (temp_mc >= trip);
  end

  assign stage_calc = hit[2] ? 2'd3 : hit[1] ? 2'd2 : hit[0] ? 2'd1 : 2'd0;
  assign stage_nx   = !alc[7] ? 2'd0 : temp_vld ? stage_calc : stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= 2'd0;
      irq_q <= 1'b0;
      sdc   <= 8'h00;
      alc   <= 8'h00;
    end else begin
      stage <= stage_nx;
      irq_q <= (stage_nx != stage);
      if (reg_wr && reg_addr == A_SDC) sdc <= reg_wdata & SDC_MASK;
      if (reg_wr && reg_addr == A_ALC) alc <= reg_wdata & ALC_MASK;
    end
  end

  assign gstate = (stage == 2'd0) ? 3'd0 : ({stage, 1'b0} - 3'd1);

  always_comb begin
    case (reg_addr)
      A_REV:   reg_rdata = REV;
      A_TYPE:  reg_rdata = 8'h09;
      A_SUB:   reg_rdata = SUBTYPE;
      A_STAT:  reg_rdata = (GEN == 1) ? {6'b0, stage} : {1'b0, gstate, 4'b0};
      A_SDC:   reg_rdata = sdc;
      A_ALC:   reg_rdata = alc;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign alarm_irq = irq_q;
  assign shutdown  = (stage == 2'd3) || (stage == 2'd2 && !sdc[6]);
endmodule

module therm_alarm_chk #(
  parameter int       GEN = 2,
  parameter bit [7:0] REV = 8'h01
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] stage,
  input logic       alarm_irq,
  input logic       shutdown,
  input logic       force_on,
  input logic       temp_vld,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata
);
  logic [1:0] prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 2'd0;
    else        prev <= stage;

  a_r5_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq == (stage != prev));
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !force_on |=> stage == 2'd0);
  a_r3_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (force_on && !temp_vld) |=> $stable(stage));
  a_r6_stage3_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd3) |-> shutdown);
  a_r6_low_stage_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stage < 2'd2) |-> !shutdown);
  a_r1_type_id: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h04) |-> reg_rdata == 8'h09);
  a_r7_gen2_state_form: assert property (@(posedge clk) disable iff (!rst_n)
    (GEN == 2 && reg_addr == 8'h08) |->
      (reg_rdata[3:0] == 4'h0 && !reg_rdata[7] && reg_rdata[4] == (stage != 2'd0)));
endmodule

bind therm_alarm therm_alarm_chk #(.GEN(GEN), .REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage(stage), .alarm_irq(alarm_irq),
  .shutdown(shutdown), .force_on(alc[7]), .temp_vld(temp_vld),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata));

// File: tb/test_therm_alarm.sv
`timescale 1ns/1ps
module test_therm_alarm;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic reg_wr = 0, temp_vld = 0;
  logic signed [31:0] temp_mc = 0;
  logic [7:0] rd [2];
  logic irq [2], shd [2];
  int total = 0, bad = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  therm_alarm #(.GEN(2), .REV(8'h01)) i_therm_alarm (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[0]), .temp_mc(temp_mc),
    .temp_vld(temp_vld), .alarm_irq(irq[0]), .shutdown(shd[0]));
  therm_alarm #(.GEN(1), .REV(8'h00)) i_therm_alarm_g1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[1]), .temp_mc(temp_mc),
    .temp_vld(temp_vld), .alarm_irq(irq[1]), .shutdown(shd[1]));

  // reference model: index 0 = gen 2 rev 1, index 1 = gen 1 rev 0
  int m_st [2], m_sdc [2], m_alc [2];
  bit m_irq [2];

  function automatic int base(int g, int k);
    if (g == 0) return (k == 0) ? 90000 : (k == 1) ? 110000 : 140000;
    return (k == 0) ? 105000 : (k == 1) ? 125000 : 145000;
  endfunction

  function automatic int exp_rd(int g, int a);
    case (a)
      8'h01: return (g == 0) ? 1 : 0;
      8'h04: return 9;
      8'h05: return (g == 0) ? 9 : 8;
      8'h08: return (g == 1) ? m_st[g] : ((m_st[g] == 0) ? 0 : (2 * m_st[g] - 1) * 16);
      8'h40: return m_sdc[g];
      8'h46: return m_alc[g];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    for (int g = 0; g < 2; g++) begin
      if (!rst_n) begin
        m_st[g] = 0; m_sdc[g] = 0; m_alc[g] = 0; m_irq[g] = 0;
      end else begin
        int nst;
        nst = m_st[g];
        if ((m_alc[g] & 8'h80) == 0) nst = 0;
        else if (temp_vld) begin
          nst = 0;
          for (int k = 0; k < 3; k++)
            if (int'(temp_mc) >= base(g, k) + 5000 * (m_sdc[g] & 3)) nst = k + 1;
        end
        m_irq[g] = (nst != m_st[g]);
        m_st[g] = nst;
        if (reg_wr && reg_addr == 8'h40) m_sdc[g] = reg_wdata & 8'h4B;
        if (reg_wr && reg_addr == 8'h46) m_alc[g] = reg_wdata & 8'h80;
      end
    end
  end

  task automatic chk(string req, int g, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s inst%0d t=%0t act=0x%0h exp=0x%0h", req, g, $time, act, exp);
    end
  endtask

  function automatic string rd_req(int a);
    case (a)
      8'h01, 8'h04, 8'h05: return "R1";
      8'h08: return "R7";
      8'h40, 8'h46: return "R2";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) if (started && !done) begin
    for (int g = 0; g < 2; g++) begin
      chk("R5", g, int'(irq[g]), int'(m_irq[g]));
      chk("R6", g, int'(shd[g]),
          int'(m_st[g] == 3 || (m_st[g] == 2 && (m_sdc[g] & 8'h40) == 0)));
      chk(rd_req(reg_addr), g, int'(rd[g]), exp_rd(g, reg_addr));
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask
  task automatic samp(int t);
    temp_mc = t; temp_vld = 1; tick(); temp_vld = 0;
    reg_addr = 8'h08; tick(); tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R2 reset values, R1 identification and unmapped read
    foreach (rd[g]) begin
      reg_addr = 8'h40; #0.1 chk("R2", g, int'(rd[g]), 0);
      reg_addr = 8'h05; #0.1 chk("R1", g, int'(rd[g]), (g == 0) ? 9 : 8);
      reg_addr = 8'h33; #0.1 chk("R1", g, int'(rd[g]), 0);
    end
    tick();
    // R4: alarm off, hot sample ignored
    samp(200000);
    foreach (rd[g]) chk("R4", g, int'(rd[g]), 0);
    wr(8'h46, 8'hFF); reg_addr = 8'h46; tick();
    wr(8'h40, 8'h00);
    // R3: sweep index 0, including exact trip points
    samp(89999); samp(90000); samp(105000); samp(110000); samp(125000);
    samp(140000); samp(145000); samp(20000); samp(-40000);
    // R3 hold: no valid sample while hot
    temp_mc = 200000; reg_addr = 8'h08; tick(); tick();
    foreach (rd[g]) chk("R3", g, int'(rd[g]), 0);
    // index 3 and override (R6)
    wr(8'h40, 8'h03); samp(130000); samp(135000); samp(160000);
    wr(8'h40, 8'h43); samp(125000); samp(140000); samp(155000);
    // R2 masking
    wr(8'h40, 8'hFF); reg_addr = 8'h40; tick();
    foreach (rd[g]) chk("R2", g, int'(rd[g]), 8'h4B);
    wr(8'h40, 8'h01); samp(118000); samp(132000);
    // R8: writes to read-only addresses
    wr(8'h08, 8'hFF); wr(8'h04, 8'h00); wr(8'h01, 8'h77);
    reg_addr = 8'h04; tick(); reg_addr = 8'h01; tick(); reg_addr = 8'h08; tick();
    reg_addr = 8'h40; tick();
    foreach (rd[g]) chk("R8", g, int'(rd[g]), 8'h01);
    // R4: turning off drops the stage
    samp(200000); wr(8'h46, 8'h00); reg_addr = 8'h08; tick(); tick();
    foreach (rd[g]) chk("R4", g, int'(rd[g]), 0);
    samp(200000);
    wr(8'h46, 8'h80); wr(8'h40, 8'h02); samp(121000); samp(0);
    tick(); tick();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule